// File: doc/BRIEF.md
# Crystal Startup Fault Guard

This block watches the startup of two crystal oscillators, a fast one and a slow one. Each oscillator has its own cycle counter. The counter advances on a one-cycle strobe that marks each good oscillator cycle; the strobe has already been brought into the system clock domain. Each oscillator also has a sticky fault flag. A fault-detect pulse sets the flag and sends the counter back to zero. Software may clear the flag only after the counter has reached the threshold that software selected. A clear request made earlier has no effect.

Software sees one 32-bit control word. For each oscillator it holds a counter enable, a two-bit threshold select and a restart bit. The restart bit is write-only: writing 1 to it zeroes the counter in the same cycle, and it always reads back as 0. A `done` output for each oscillator shows that its counter has reached the selected threshold.

Top module: `xtal_start_guard`

## Requirements
- R1: After reset the control word reads 0x000000BB, both fault flags are 1, and both `done` outputs are 0.
- R2: Control word field positions: bit 7 is the fast enable, bit 6 the fast restart, bits 5:4 the fast threshold select, bit 3 the slow enable, bit 2 the slow restart and bits 1:0 the slow threshold select. Bits 31:8 and the restart bits 6 and 2 always read 0, and writes to bits 31:8 have no effect.
- R3: The fast threshold is 2048 cycles shifted left by its select value (00 gives 2048, 01 gives 4096, 10 gives 8192, 11 gives 16384).
- R4: The slow threshold is 4096 cycles shifted left by its select value (00 gives 4096, 01 gives 8192, 10 gives 16384, 11 gives 32768).
- R5: While its counter is enabled, each counter rises by one on every clock with its strobe high. It stops rising once it reaches its threshold, so raising the select afterwards leaves `done` low.
- R6: `done` is high exactly when the counter is enabled and its count is at least the threshold. If a write lowers the select below the current count, `done` is high in the cycle after that write.
- R7: A clear request while `done` is low leaves the fault flag set.
- R8: A clear request while `done` is high drops the fault flag on the next clock. A fault pulse in the same cycle wins, and the flag stays set.
- R9: A fault pulse sets the flag on the next clock and returns that counter to zero, which drops `done`.
- R10: Writing 1 to a restart bit zeroes that counter at the write's clock edge. The other fields in the same write are stored as written.
- R11: While an enable bit is 0, its counter is held at zero and its `done` is low. Strobes received in that time are not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | 32 | Value written to the control word |
| reg_rd_data | output | 32 | Current control word |
| hf_tick | input | 1 | One good fast-oscillator cycle |
| lf_tick | input | 1 | One good slow-oscillator cycle |
| hf_fault | input | 1 | Fast-oscillator fault-detect pulse |
| lf_fault | input | 1 | Slow-oscillator fault-detect pulse |
| hf_flag_clr | input | 1 | Software clear request, fast flag |
| lf_flag_clr | input | 1 | Software clear request, slow flag |
| hf_flag | output | 1 | Fast-oscillator fault flag |
| lf_flag | output | 1 | Slow-oscillator fault flag |
| hf_done | output | 1 | Fast counter at or above its threshold |
| lf_done | output | 1 | Slow counter at or above its threshold |

## Verification
The hardest situation to create from the ports is a counter that sits above its threshold. The counter saturates, so plain counting cannot get it there. The stimulus counts 3000 strobes with the largest fast threshold selected, then writes a smaller select and checks that `done` rises at once. The opposite case also matters: a counter saturated at the smallest threshold followed by a larger select. It shows that strobes beyond the threshold were not kept, because exactly the difference in strobes is then needed before `done` rises again.

// File: rtl/xsg_pkg.sv
package xsg_pkg;
   localparam int REG_W    = 32;
   localparam int SEL_W    = 2;
   localparam int N_CHAN   = 2;
   // control word layout, decoded by software
   localparam int HF_EN_B  = 7;
   localparam int HF_RS_B  = 6;
   localparam int HF_SEL_L = 4;
   localparam int LF_EN_B  = 3;
   localparam int LF_RS_B  = 2;
   localparam int LF_SEL_L = 0;

   typedef struct packed {
      logic             en;
      logic [SEL_W-1:0] sel;
   } chan_cfg_t;
endpackage

// File: rtl/xsg_cfg_reg.sv
module xsg_cfg_reg
   import xsg_pkg::*;
#(
   parameter int RST_VAL = 32'h0000_00BB
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] rd_data,
   output chan_cfg_t        hf_cfg,
   output chan_cfg_t        lf_cfg,
   output logic             hf_restart,
   output logic             lf_restart
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hf_cfg.en  <= RST_VAL[HF_EN_B];
         hf_cfg.sel <= RST_VAL[HF_SEL_L +: SEL_W];
         lf_cfg.en  <= RST_VAL[LF_EN_B];
         lf_cfg.sel <= RST_VAL[LF_SEL_L +: SEL_W];
      end else if (wr_en) begin
         hf_cfg.en  <= wr_data[HF_EN_B];
         hf_cfg.sel <= wr_data[HF_SEL_L +: SEL_W];
         lf_cfg.en  <= wr_data[LF_EN_B];
         lf_cfg.sel <= wr_data[LF_SEL_L +: SEL_W];
      end
   end

   // restart bits are pulses, never stored
   assign hf_restart = wr_en & wr_data[HF_RS_B];
   assign lf_restart = wr_en & wr_data[LF_RS_B];

   always_comb begin
      rd_data                      = '0;
      rd_data[HF_EN_B]             = hf_cfg.en;
      rd_data[HF_SEL_L +: SEL_W]   = hf_cfg.sel;
      rd_data[LF_EN_B]             = lf_cfg.en;
      rd_data[LF_SEL_L +: SEL_W]   = lf_cfg.sel;
   end
endmodule

// File: rtl/xsg_osc_chan.sv
module xsg_osc_chan
   import xsg_pkg::*;
#(
   parameter int   BASE     = 2048,
   parameter logic FLAG_RST = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  chan_cfg_t cfg,
   input  logic      restart,
   input  logic      tick,
   input  logic      fault,
   input  logic      clr,
   output logic      flag,
   output logic      done
);
   localparam int MAX_THR = BASE << ((1 << SEL_W) - 1);
   localparam int CW      = $clog2(MAX_THR) + 1;

   if (BASE < 1 || (BASE & (BASE - 1)) != 0) begin : g_bad_base
      $error("xsg_osc_chan: BASE must be a power of two");
   end

   logic [CW-1:0] cnt_q;
   logic [CW-1:0] thresh;
   logic          at_thr;
   logic          flag_q;

   assign thresh = CW'(BASE) << cfg.sel;
   assign at_thr = (cnt_q >= thresh);
   assign done   = cfg.en & at_thr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         cnt_q <= '0;
      else if (!cfg.en || restart || fault) cnt_q <= '0;
      else if (tick && !at_thr)           cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flag_q <= FLAG_RST;
      else if (fault)        flag_q <= 1'b1;
      else if (clr && done)  flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/xtal_start_guard.sv
module xtal_start_guard
   import xsg_pkg::*;
#(
   parameter int HF_BASE = 2048,
   parameter int LF_BASE = 4096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wr_data,
   output logic [REG_W-1:0] reg_rd_data,
   input  logic             hf_tick,
   input  logic             lf_tick,
   input  logic             hf_fault,
   input  logic             lf_fault,
   input  logic             hf_flag_clr,
   input  logic             lf_flag_clr,
   output logic             hf_flag,
   output logic             lf_flag,
   output logic             hf_done,
   output logic             lf_done
);
   chan_cfg_t               cfg_v   [N_CHAN];
   logic [N_CHAN-1:0]       rst_v, tick_v, fault_v, clr_v, flag_v, done_v;

   xsg_cfg_reg u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr_en),
      .wr_data    (reg_wr_data),
      .rd_data    (reg_rd_data),
      .hf_cfg     (cfg_v[0]),
      .lf_cfg     (cfg_v[1]),
      .hf_restart (rst_v[0]),
      .lf_restart (rst_v[1])
   );

   assign tick_v  = {lf_tick, hf_tick};
   assign fault_v = {lf_fault, hf_fault};
   assign clr_v   = {lf_flag_clr, hf_flag_clr};

   for (genvar g = 0; g < N_CHAN; g++) begin : g_chan
      localparam int B = (g == 0) ? HF_BASE : LF_BASE;
      xsg_osc_chan #(.BASE(B)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .cfg     (cfg_v[g]),
         .restart (rst_v[g]),
         .tick    (tick_v[g]),
         .fault   (fault_v[g]),
         .clr     (clr_v[g]),
         .flag    (flag_v[g]),
         .done    (done_v[g])
      );
   end

   assign hf_flag = flag_v[0];
   assign lf_flag = flag_v[1];
   assign hf_done = done_v[0];
   assign lf_done = done_v[1];
endmodule

// File: rtl/xsg_chk.sv
module xsg_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        reg_wr_en,
   input logic [31:0] reg_wr_data,
   input logic [31:0] reg_rd_data,
   input logic        hf_fault,
   input logic        lf_fault,
   input logic        hf_flag,
   input logic        lf_flag,
   input logic        hf_done,
   input logic        lf_done
);
   // R2
   rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd_data[31:8] == '0 && !reg_rd_data[6] && !reg_rd_data[2]);
   // R7
   hf_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hf_flag && !hf_done |=> hf_flag);
   // R7
   lf_flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lf_flag && !lf_done |=> lf_flag);
   // R11
   hf_done_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hf_done |-> reg_rd_data[7]);
   // R11
   lf_done_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lf_done |-> reg_rd_data[3]);
   // R9
   hf_fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hf_fault |=> hf_flag && !hf_done);
   // R9
   lf_fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lf_fault |=> lf_flag && !lf_done);
   // R10
   hf_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en && reg_wr_data[6] |=> !hf_done);
   // R10
   lf_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr_en && reg_wr_data[2] |=> !lf_done);
endmodule

bind xtal_start_guard xsg_chk u_xsg_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_wr_en   (reg_wr_en),
   .reg_wr_data (reg_wr_data),
   .reg_rd_data (reg_rd_data),
   .hf_fault    (hf_fault),
   .lf_fault    (lf_fault),
   .hf_flag     (hf_flag),
   .lf_flag     (lf_flag),
   .hf_done     (hf_done),
   .lf_done     (lf_done)
);

// File: tb/xtal_start_guard_tb_top.sv
module xtal_start_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr_en = 1'b0;
   logic [31:0] reg_wr_data = '0;
   logic [31:0] reg_rd_data;
   logic        hf_tick = 0, lf_tick = 0, hf_fault = 0, lf_fault = 0;
   logic        hf_flag_clr = 0, lf_flag_clr = 0;
   logic        hf_flag, lf_flag, hf_done, lf_done;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2.5 clk = ~clk;

   xtal_start_guard dut_i (.*);

   localparam int NV = 6;
   localparam logic [31:0] VEC_WR [NV] = '{32'hFFFF_FFFF, 32'h0, 32'h55, 32'hAA, 32'h44, 32'h9A};
   localparam logic [31:0] VEC_RD [NV] = '{32'hBB,        32'h0, 32'h11, 32'hAA, 32'h00, 32'h9A};

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] d);
      @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
      @(negedge clk); reg_wr_en = 1'b0; reg_wr_data = '0;
   endtask

   task automatic hf_ticks(int n);
      @(negedge clk); hf_tick = 1'b1;
      repeat (n) @(negedge clk);
      hf_tick = 1'b0;
   endtask

   task automatic lf_ticks(int n);
      @(negedge clk); lf_tick = 1'b1;
      repeat (n) @(negedge clk);
      lf_tick = 1'b0;
   endtask

   task automatic hf_clr();
      @(negedge clk); hf_flag_clr = 1'b1;
      @(negedge clk); hf_flag_clr = 1'b0;
   endtask

   task automatic lf_clr();
      @(negedge clk); lf_flag_clr = 1'b1;
      @(negedge clk); lf_flag_clr = 1'b0;
   endtask

   initial begin
      #(5 * 150000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rd", reg_rd_data, 32'hBB);
      check("R1 flags", {hf_flag, lf_flag}, 2'b11);
      check("R1 done", {hf_done, lf_done}, 2'b00);

      // R2 field layout and reserved bits, table walk
      for (int i = 0; i < NV; i++) begin
         wr(VEC_WR[i]);
         check("R2 vector", reg_rd_data, VEC_RD[i]);
      end

      // R3 fast threshold 2048 with select 00; R7 early clear ignored
      wr(32'h88);
      hf_ticks(2047);
      check("R3 not yet", hf_done, 1'b0);
      hf_clr();
      check("R7 hf clr blocked", hf_flag, 1'b1);
      hf_ticks(1);
      check("R3 hf done at 2048", hf_done, 1'b1);
      hf_clr();
      check("R8 hf clr", hf_flag, 1'b0);

      // R5 saturation: extra ticks are not kept
      hf_ticks(10);
      wr(32'h98);
      check("R5 saturated below 4096", hf_done, 1'b0);
      hf_ticks(2047);
      check("R5 still short", hf_done, 1'b0);
      hf_ticks(1);
      check("R3 hf done at 4096", hf_done, 1'b1);

      // R9 fault sets flag and restarts counter
      @(negedge clk); hf_fault = 1'b1;
      @(negedge clk); hf_fault = 1'b0;
      check("R9 hf flag", hf_flag, 1'b1);
      check("R9 hf done cleared", hf_done, 1'b0);

      // R10 restart bit
      wr(32'h88);
      hf_ticks(2048);
      check("R10 pre", hf_done, 1'b1);
      wr(32'hC8);
      check("R10 hf restart", hf_done, 1'b0);
      check("R10 reads 0", reg_rd_data, 32'h88);

      // R8 fault beats clear in same cycle
      hf_ticks(2048);
      @(negedge clk); hf_fault = 1'b1; hf_flag_clr = 1'b1;
      @(negedge clk); hf_fault = 1'b0; hf_flag_clr = 1'b0;
      check("R8 fault wins", hf_flag, 1'b1);

      // R6 lowering select above count
      wr(32'hB8);
      hf_ticks(3000);
      check("R6 below 16384", hf_done, 1'b0);
      wr(32'h88);
      check("R6 lowered select", hf_done, 1'b1);

      // R11 enable off holds zero
      wr(32'h08);
      check("R11 done low off", hf_done, 1'b0);
      hf_ticks(100);
      wr(32'h88);
      check("R11 held zero", hf_done, 1'b0);
      hf_ticks(2047);
      check("R11 recount short", hf_done, 1'b0);
      hf_ticks(1);
      check("R11 recount done", hf_done, 1'b1);

      // R4 slow threshold 4096, R7/R8 on slow flag
      lf_ticks(4095);
      check("R4 lf not yet", lf_done, 1'b0);
      lf_clr();
      check("R7 lf clr blocked", lf_flag, 1'b1);
      lf_ticks(1);
      check("R4 lf done at 4096", lf_done, 1'b1);
      lf_clr();
      check("R8 lf clr", lf_flag, 1'b0);
      wr(32'h8C);
      check("R10 lf restart", lf_done, 1'b0);
      check("R10 lf reads 0", reg_rd_data, 32'h88);
      @(negedge clk); lf_fault = 1'b1;
      @(negedge clk); lf_fault = 1'b0;
      check("R9 lf flag", lf_flag, 1'b1);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end
endmodule